// File: doc/BRIEF.md
# Display Controller Register File

This block is the software-visible control and status bank of a framebuffer display controller. A host reaches it over a 32-bit Wishbone-style slave port with four byte-lane selects. The bank holds six storage words: a control word, a horizontal timing word, a vertical timing word, a combined line/frame length word and two video base addresses. It also holds one status word. The control word is decoded into separate fields, and these fields together with the timing and length words go straight to the video datapath.

The status word gathers event pulses from the datapath: end of line, end of frame and line-buffer underrun. It also records the bank switches that the block performs itself. When bank switching is enabled, each end-of-frame pulse flips the active video base (A/B) and the active colour lookup bank. A single interrupt line combines the pending flags with their enable bits. The underrun flag drives the interrupt whatever the enables are.

Top module: `dispctl_regs`

## Requirements
- R1: After reset every readable word is zero: control, status, both timing words, length and both base addresses. The decoded outputs, `video_base`, `lut_bank` and `irq` are also zero.
- R2: The horizontal timing (byte offset 0x08), vertical timing (0x0C) and length (0x10) words read back all 32 written bits. They appear unchanged on `htiming`, `vtiming` and `frame_len`.
- R3: Base address A (0x14) and base address B (0x18) always read bits 1:0 as zero. `video_base` always has bits 1:0 at zero.
- R4: The control word (0x00) keeps bits 15:0 and reads bits 31:16 as zero. The decode is:
  - bit 0: `video_en`
  - bit 1: frame interrupt enable
  - bit 2: line interrupt enable
  - bit 3: video bank interrupt enable
  - bit 4: lookup bank interrupt enable
  - bit 5: video bank switch enable
  - bit 6: lookup bank switch enable
  - bits 8:7: `burst_len`
  - bits 10:9: `color_depth`
  - bit 11: `pseudo_color`
  - bits 12 to 15: `hsync_pol`, `vsync_pol`, `csync_pol` and `blank_pol`, in that order.
- R5: A write changes only the byte lanes whose `sel_i` bit is set. Lane n covers bits 8n+7:8n.
- R6: Each request (`cyc_i` and `stb_i` high) gets `ack_o` for exactly one cycle, on the clock edge after the request is seen. Read data is valid on `dat_o` while `ack_o` is high.
- R7: Event pulses set status flags: `evt_frame` sets bit 0, `evt_underrun` sets bit 1 and `evt_line` sets bit 4. Status bit 16 shows the active video bank and bit 17 the active lookup bank.
- R8: Writing 1 to a status flag with `sel_i[0]` set clears that flag. Writing 0 leaves it unchanged. If an event arrives in the same cycle as a clear, the flag stays set.
- R9: `irq` is high when any of these holds: bit 0 and enable bit 1, bit 4 and enable bit 2, bit 5 and enable bit 3, bit 6 and enable bit 4, or bit 1 alone. `irq` rises on the same edge that sets the flag.
- R10: With control bit 5 set, each `evt_frame` flips the active video bank and sets status bit 5. `video_base` then presents base B when the bank is 1 and base A when it is 0. With bit 5 clear, the bank holds.
- R11: With control bit 6 set, each `evt_frame` flips `lut_bank` and sets status bit 6.
- R12: Offset 0x1C holds nothing: it reads zero and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write when high, read when low |
| adr_i | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) |
| sel_i | input | 4 | Byte-lane selects |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack |
| ack_o | output | 1 | One-cycle acknowledge |
| evt_line | input | 1 | End-of-line pulse |
| evt_frame | input | 1 | End-of-frame pulse |
| evt_underrun | input | 1 | Line-buffer underrun pulse |
| video_en | output | 1 | Video enable |
| burst_len | output | 2 | Burst length select |
| color_depth | output | 2 | Colour depth select |
| pseudo_color | output | 1 | Pseudo-colour mode |
| hsync_pol | output | 1 | Horizontal sync polarity |
| vsync_pol | output | 1 | Vertical sync polarity |
| csync_pol | output | 1 | Composite sync polarity |
| blank_pol | output | 1 | Blank polarity |
| htiming | output | 32 | Horizontal timing word |
| vtiming | output | 32 | Vertical timing word |
| frame_len | output | 32 | Line and frame length word |
| video_base | output | 32 | Base address of the active video bank |
| lut_bank | output | 1 | Active colour lookup bank |
| irq | output | 1 | Interrupt request |

## Verification
A host write-one-to-clear of a status flag and the datapath event that sets that same flag can land in the same clock cycle. The bench provokes this by driving `evt_line` on the same cycle as a write of 1 to status bit 4. It then reads the status word and expects bit 4 still set, because the event must win. A second overlap occurs when an end-of-frame pulse sets several flags and flips the bank selectors at once. The bench judges this through one status read carrying bits 0, 5 and 16 (or 0, 6 and 17), together with the `video_base`, `lut_bank` and `irq` outputs.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  localparam int unsigned BUS_W    = 32;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned NUM_REGS = 7;

  // word index = byte offset / 4
  localparam int unsigned RI_CTRL  = 0;
  localparam int unsigned RI_STAT  = 1;
  localparam int unsigned RI_HTIM  = 2;
  localparam int unsigned RI_VTIM  = 3;
  localparam int unsigned RI_LEN   = 4;
  localparam int unsigned RI_BASEA = 5;
  localparam int unsigned RI_BASEB = 6;

  // control bit positions
  localparam int unsigned CB_VEN    = 0;
  localparam int unsigned CB_FIE    = 1;
  localparam int unsigned CB_LIE    = 2;
  localparam int unsigned CB_VBIE   = 3;
  localparam int unsigned CB_LBIE   = 4;
  localparam int unsigned CB_VBSW   = 5;
  localparam int unsigned CB_LBSW   = 6;
  localparam int unsigned CB_BURST  = 7;
  localparam int unsigned CB_DEPTH  = 9;
  localparam int unsigned CB_PSEUDO = 11;
  localparam int unsigned CB_POL    = 12;

  // status bit positions
  localparam int unsigned SB_FRAME = 0;
  localparam int unsigned SB_UNDER = 1;
  localparam int unsigned SB_LINE  = 4;
  localparam int unsigned SB_VBANK = 5;
  localparam int unsigned SB_LBANK = 6;
  localparam int unsigned SB_VSEL  = 16;
  localparam int unsigned SB_LSEL  = 17;

  // internal flag vector order
  typedef struct packed {
    logic lbank;
    logic vbank;
    logic line;
    logic under;
    logic frame;
  } flags_t;

  function automatic logic [BUS_W-1:0] keep_mask(int unsigned idx);
    case (idx)
      RI_CTRL:            return 32'h0000_FFFF;
      RI_BASEA, RI_BASEB: return 32'hFFFF_FFFC;
      default:            return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dispctl_word.sv
module dispctl_word #(
  parameter int unsigned           WIDTH  = 32,
  parameter int unsigned           LANE   = 8,
  parameter logic [WIDTH-1:0]      KEEP   = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [WIDTH/LANE-1:0]    sel,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         q
);
  localparam int unsigned LANES = WIDTH / LANE;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        q[ln*LANE +: LANE] <= '0;
      else if (wr_en && sel[ln])
        q[ln*LANE +: LANE] <= wdata[ln*LANE +: LANE] & KEEP[ln*LANE +: LANE];
    end
  end
endmodule

// File: rtl/dispctl_status.sv
module dispctl_status
  import dispctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   evt_line,
  input  logic   evt_frame,
  input  logic   evt_underrun,
  input  logic   clr_wr,
  input  flags_t clr_bits,
  input  flags_t irq_en,
  input  logic   vbank_sw_en,
  input  logic   lbank_sw_en,
  output flags_t flags,
  output logic   vbank,
  output logic   lbank,
  output logic   irq
);
  flags_t set_v, clr_v, flags_d;
  logic   vflip, lflip;

  always_comb begin
    vflip       = evt_frame && vbank_sw_en;
    lflip       = evt_frame && lbank_sw_en;
    set_v.frame = evt_frame;
    set_v.under = evt_underrun;
    set_v.line  = evt_line;
    set_v.vbank = vflip;
    set_v.lbank = lflip;
    clr_v       = clr_wr ? clr_bits : '0;
    // a new event overrides a clear in the same cycle
    flags_d     = (flags & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      vbank <= 1'b0;
      lbank <= 1'b0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      vbank <= vbank ^ vflip;
      lbank <= lbank ^ lflip;
      irq   <= |(flags_d & irq_en);
    end
  end
endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dispctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:2] adr_i,
  input  logic [3:0]        sel_i,
  input  logic [31:0]       dat_i,
  output logic [31:0]       dat_o,
  output logic              ack_o,
  input  logic              evt_line,
  input  logic              evt_frame,
  input  logic              evt_underrun,
  output logic              video_en,
  output logic [1:0]        burst_len,
  output logic [1:0]        color_depth,
  output logic              pseudo_color,
  output logic              hsync_pol,
  output logic              vsync_pol,
  output logic              csync_pol,
  output logic              blank_pol,
  output logic [31:0]       htiming,
  output logic [31:0]       vtiming,
  output logic [31:0]       frame_len,
  output logic [31:0]       video_base,
  output logic              lut_bank,
  output logic              irq
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned SLOTS  = 2 ** IDX_W;
  localparam int unsigned LANES  = BUS_W / LANE_W;

  logic [BUS_W-1:0] word_q [SLOTS];
  logic [BUS_W-1:0] ctrl_q, stat_word, rd_mux;
  logic             req, wr;
  flags_t           flags, clr_bits, irq_en;
  logic             vid_bank, vbank_sw_en, lbank_sw_en;

  assign req = cyc_i && stb_i && !ack_o;
  assign wr  = req && we_i;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g >= NUM_REGS) begin : g_hole
      assign word_q[g] = '0;
    end else if (g == RI_STAT) begin : g_stat
      assign word_q[g] = stat_word;
    end else begin : g_store
      dispctl_word #(
        .WIDTH (BUS_W),
        .LANE  (LANE_W),
        .KEEP  (keep_mask(g))
      ) i_word (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr && (adr_i == IDX_W'(g))),
        .sel   (sel_i[LANES-1:0]),
        .wdata (dat_i),
        .q     (word_q[g])
      );
    end
  end

  assign ctrl_q      = word_q[RI_CTRL];
  assign vbank_sw_en = ctrl_q[CB_VBSW];
  assign lbank_sw_en = ctrl_q[CB_LBSW];

  always_comb begin
    irq_en.frame    = ctrl_q[CB_FIE];
    irq_en.line     = ctrl_q[CB_LIE];
    irq_en.vbank    = ctrl_q[CB_VBIE];
    irq_en.lbank    = ctrl_q[CB_LBIE];
    irq_en.under    = 1'b1;
    clr_bits.frame  = dat_i[SB_FRAME];
    clr_bits.under  = dat_i[SB_UNDER];
    clr_bits.line   = dat_i[SB_LINE];
    clr_bits.vbank  = dat_i[SB_VBANK];
    clr_bits.lbank  = dat_i[SB_LBANK];
  end

  dispctl_status i_status (
    .clk          (clk),
    .rst          (rst),
    .evt_line     (evt_line),
    .evt_frame    (evt_frame),
    .evt_underrun (evt_underrun),
    .clr_wr       (wr && (adr_i == IDX_W'(RI_STAT)) && sel_i[0]),
    .clr_bits     (clr_bits),
    .irq_en       (irq_en),
    .vbank_sw_en  (vbank_sw_en),
    .lbank_sw_en  (lbank_sw_en),
    .flags        (flags),
    .vbank        (vid_bank),
    .lbank        (lut_bank),
    .irq          (irq)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[SB_FRAME] = flags.frame;
    stat_word[SB_UNDER] = flags.under;
    stat_word[SB_LINE]  = flags.line;
    stat_word[SB_VBANK] = flags.vbank;
    stat_word[SB_LBANK] = flags.lbank;
    stat_word[SB_VSEL]  = vid_bank;
    stat_word[SB_LSEL]  = lut_bank;
    rd_mux              = word_q[adr_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o      <= 1'b0;
      dat_o      <= '0;
      video_base <= '0;
    end else begin
      ack_o      <= req;
      dat_o      <= (req && !we_i) ? rd_mux : '0;
      video_base <= vid_bank ? word_q[RI_BASEB] : word_q[RI_BASEA];
    end
  end

  assign video_en     = ctrl_q[CB_VEN];
  assign burst_len    = ctrl_q[CB_BURST +: 2];
  assign color_depth  = ctrl_q[CB_DEPTH +: 2];
  assign pseudo_color = ctrl_q[CB_PSEUDO];
  assign hsync_pol    = ctrl_q[CB_POL];
  assign vsync_pol    = ctrl_q[CB_POL+1];
  assign csync_pol    = ctrl_q[CB_POL+2];
  assign blank_pol    = ctrl_q[CB_POL+3];
  assign htiming      = word_q[RI_HTIM];
  assign vtiming      = word_q[RI_VTIM];
  assign frame_len    = word_q[RI_LEN];
endmodule

// File: rtl/dispctl_regs_chk.sv
module dispctl_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        cyc_i,
  input logic        stb_i,
  input logic        ack_o,
  input logic        evt_frame,
  input logic        evt_underrun,
  input logic        irq,
  input logic        vid_bank,
  input logic        vbank_sw_en,
  input logic [31:0] video_base
);
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);  // R6

  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(cyc_i && stb_i));  // R6

  AST_UNDERRUN_IRQ: assert property (@(posedge clk) disable iff (rst)
    evt_underrun |=> irq);  // R9

  AST_BANK_FLIP: assert property (@(posedge clk) disable iff (rst)
    (evt_frame && vbank_sw_en) |=> (vid_bank != $past(vid_bank)));  // R10

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(evt_frame && vbank_sw_en) |=> $stable(vid_bank));  // R10

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    video_base[1:0] == 2'b00);  // R3
endmodule

bind dispctl_regs dispctl_regs_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .cyc_i        (cyc_i),
  .stb_i        (stb_i),
  .ack_o        (ack_o),
  .evt_frame    (evt_frame),
  .evt_underrun (evt_underrun),
  .irq          (irq),
  .vid_bank     (vid_bank),
  .vbank_sw_en  (vbank_sw_en),
  .video_base   (video_base)
);

// File: tb/test_dispctl_regs.sv
module test_dispctl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_i = 0, stb_i = 0, we_i = 0;
  logic [4:2]  adr_i = '0;
  logic [3:0]  sel_i = '0;
  logic [31:0] dat_i = '0;
  logic [31:0] dat_o;
  logic        ack_o;
  logic        evt_line = 0, evt_frame = 0, evt_underrun = 0;
  logic        video_en, pseudo_color, hsync_pol, vsync_pol, csync_pol, blank_pol;
  logic [1:0]  burst_len, color_depth;
  logic [31:0] htiming, vtiming, frame_len, video_base;
  logic        lut_bank, irq;

  always #5 clk = ~clk;

  dispctl_regs i_dispctl_regs (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .sel_i(sel_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o),
    .evt_line(evt_line), .evt_frame(evt_frame), .evt_underrun(evt_underrun),
    .video_en(video_en), .burst_len(burst_len), .color_depth(color_depth),
    .pseudo_color(pseudo_color), .hsync_pol(hsync_pol), .vsync_pol(vsync_pol),
    .csync_pol(csync_pol), .blank_pol(blank_pol), .htiming(htiming),
    .vtiming(vtiming), .frame_len(frame_len), .video_base(video_base),
    .lut_bank(lut_bank), .irq(irq)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t sb_q[$];
  int checks = 0;
  int errors = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read acknowledge against the scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst && ack_o && !we_i) begin
      if (sb_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6 unexpected read ack actual=%h expected=none", dat_o);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(it.tag, dat_o, it.exp);
      end
    end
  end

  task automatic bus_write(logic [4:0] addr, logic [3:0] sel, logic [31:0] data);
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = 1; adr_i = addr[4:2]; sel_i = sel; dat_i = data;
    @(negedge clk);
    cyc_i = 0; stb_i = 0; we_i = 0; sel_i = '0;
  endtask

  task automatic bus_read(logic [4:0] addr, logic [31:0] exp, string tag);
    rd_item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = 0; adr_i = addr[4:2];
    @(negedge clk);
    cyc_i = 0; stb_i = 0;
  endtask

  task automatic pulse(logic ln, logic fr, logic un);
    @(negedge clk);
    evt_line = ln; evt_frame = fr; evt_underrun = un;
    @(negedge clk);
    evt_line = 0; evt_frame = 0; evt_underrun = 0;
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R6 missing read acks actual=%0d expected=0", sb_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 outputs", {video_en, burst_len, color_depth, pseudo_color, hsync_pol,
          vsync_pol, csync_pol, blank_pol, lut_bank, irq}, 32'h0);
    check("R1 video_base", video_base, 32'h0);
    for (int i = 0; i < 7; i++) bus_read(5'(i * 4), 32'h0, "R1 reset read");

    // R2 timing and length
    bus_write(5'h08, 4'hF, 32'hA5A5_1234);
    bus_write(5'h0C, 4'hF, 32'h5A5A_8765);
    bus_write(5'h10, 4'hF, 32'hFFFF_FFFF);
    bus_read(5'h08, 32'hA5A5_1234, "R2 htim");
    bus_read(5'h0C, 32'h5A5A_8765, "R2 vtim");
    bus_read(5'h10, 32'hFFFF_FFFF, "R2 len");
    check("R2 htiming out", htiming, 32'hA5A5_1234);
    check("R2 vtiming out", vtiming, 32'h5A5A_8765);
    check("R2 frame_len out", frame_len, 32'hFFFF_FFFF);

    // R3 base alignment
    bus_write(5'h14, 4'hF, 32'hFFFF_FFFF);
    bus_write(5'h18, 4'hF, 32'h1234_5677);
    bus_read(5'h14, 32'hFFFF_FFFC, "R3 base A");
    bus_read(5'h18, 32'h1234_5674, "R3 base B");
    check("R3 video_base bank A", video_base, 32'hFFFF_FFFC);

    // R4 control decode
    bus_write(5'h00, 4'hF, 32'hDEAD_F980);
    bus_read(5'h00, 32'h0000_F980, "R4 ctrl reserved");
    check("R4 decode A", {video_en, burst_len, color_depth, pseudo_color,
          hsync_pol, vsync_pol, csync_pol, blank_pol},
          {1'b0, 2'd3, 2'd0, 1'b1, 4'hF});
    bus_write(5'h00, 4'hF, 32'h0000_0401);
    check("R4 decode B", {video_en, burst_len, color_depth, pseudo_color,
          hsync_pol, vsync_pol, csync_pol, blank_pol},
          {1'b1, 2'd0, 2'd2, 1'b0, 4'h0});

    // R5 byte lanes
    bus_write(5'h08, 4'b0101, 32'h1177_2288);
    bus_read(5'h08, 32'hA577_1288, "R5 partial lanes");

    // R12 hole
    bus_write(5'h1C, 4'hF, 32'hFFFF_FFFF);
    bus_read(5'h1C, 32'h0, "R12 hole reads zero");
    bus_read(5'h08, 32'hA577_1288, "R12 htim untouched");

    // R7 / R8 flags with all enables off
    bus_write(5'h00, 4'hF, 32'h0);
    pulse(1, 0, 0);
    check("R9 line flag without enable", {31'h0, irq}, 32'h0);
    bus_read(5'h04, 32'h0000_0010, "R7 line flag");
    pulse(0, 1, 0);
    bus_read(5'h04, 32'h0000_0011, "R7 frame flag no bank flip");
    bus_write(5'h04, 4'h1, 32'h0000_0001);
    bus_read(5'h04, 32'h0000_0010, "R8 clear frame");
    bus_write(5'h04, 4'h1, 32'h0);
    bus_read(5'h04, 32'h0000_0010, "R8 write zero keeps");
    bus_write(5'h04, 4'h0, 32'h0000_0010);
    bus_read(5'h04, 32'h0000_0010, "R5 no lane no clear");
    bus_write(5'h04, 4'h1, 32'h0000_0010);
    bus_read(5'h04, 32'h0, "R8 clear line");

    // R9 interrupt sources
    bus_write(5'h00, 4'hF, 32'h0000_0002);
    pulse(0, 1, 0);
    check("R9 frame irq", {31'h0, irq}, 32'h1);
    bus_write(5'h04, 4'h1, 32'h0000_0001);
    check("R9 irq drops on clear", {31'h0, irq}, 32'h0);
    bus_write(5'h00, 4'hF, 32'h0);
    pulse(0, 0, 1);
    check("R9 underrun irq", {31'h0, irq}, 32'h1);
    bus_read(5'h04, 32'h0000_0002, "R7 underrun flag");
    bus_write(5'h04, 4'h1, 32'h0000_0002);
    check("R9 underrun cleared", {31'h0, irq}, 32'h0);
    bus_write(5'h00, 4'hF, 32'h0000_0004);
    pulse(1, 0, 0);
    check("R9 line irq", {31'h0, irq}, 32'h1);
    bus_write(5'h04, 4'h1, 32'h0000_0010);
    check("R9 line irq cleared", {31'h0, irq}, 32'h0);

    // R8 event and clear in the same cycle: event wins
    bus_write(5'h00, 4'hF, 32'h0);
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = 1; adr_i = 3'd1; sel_i = 4'h1;
    dat_i = 32'h0000_0010; evt_line = 1;
    @(negedge clk);
    cyc_i = 0; stb_i = 0; we_i = 0; sel_i = '0; evt_line = 0;
    bus_read(5'h04, 32'h0000_0010, "R8 event beats clear");
    bus_write(5'h04, 4'h1, 32'h0000_0010);

    // R10 video bank switching
    bus_write(5'h00, 4'hF, 32'h0000_0021);
    pulse(0, 1, 0);
    check("R10 no irq without enable", {31'h0, irq}, 32'h0);
    bus_read(5'h04, 32'h0001_0021, "R10 bank B status");
    check("R10 video_base B", video_base, 32'h1234_5674);
    pulse(0, 1, 0);
    bus_read(5'h04, 32'h0000_0021, "R10 bank A status");
    check("R10 video_base A", video_base, 32'hFFFF_FFFC);
    bus_write(5'h04, 4'h1, 32'h0000_0073);

    // R11 lookup bank switching with its interrupt
    bus_write(5'h00, 4'hF, 32'h0000_0050);
    pulse(0, 1, 0);
    check("R11 lut_bank", {31'h0, lut_bank}, 32'h1);
    check("R11 lookup bank irq", {31'h0, irq}, 32'h1);
    bus_read(5'h04, 32'h0002_0041, "R11 status");
    check("R10 video bank held", video_base, 32'hFFFF_FFFC);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule